// File: doc/BRIEF.md
# Bus Master Address-Modifier Selector

This block sits between a local processor and a backplane master interface. For each master cycle request it chooses the 6-bit address-modifier code to place on the backplane and says whether a 32-bit data transfer is allowed. The choice depends on three inputs: the cycle address, the processor's 3-bit function code, and an 8-bit master configuration register that the processor reads and writes at one fixed local address.

Three address spaces are available: short (16-bit), standard (24-bit) and extended (32-bit). The short space is chosen by a configuration bit or by the top 64 KiB of the address map. It takes precedence over the standard space. The standard space is chosen by another configuration bit or by the bottom 16 MiB. Within a space, the function code picks the user or supervisor code and the data or program code. When the configuration register enables override mode, a separately programmed modifier value is used in place of the derived code. The upper four configuration bits steer logic outside this block, so here they are only stored and read back.

The result is registered. It appears one clock after the request, together with a valid flag or an invalid-cycle flag.

Top module: `am_select`

## Requirements
- R1: After reset, all eight configuration bits are 0, and `am_valid`, `cyc_invalid`, `d32_ok` and `am_out` are 0.
- R2: A write with `loc_wr` high at address 0xFFFE2005 stores `loc_wdata` into the configuration register at that rising clock edge. A write strobe at any other address leaves the register unchanged.
- R3: `loc_rdata` returns the eight stored bits when `loc_rd` is high and `loc_addr` is 0xFFFE2005. Otherwise it is 0.
- R4: On a valid cycle, `d32_ok` is 1 only when configuration bit 0 (16-bit-only) is clear and the address is below 0xF0000000. At or above 0xF0000000 it is always 0.
- R5: When configuration bit 1 (standard-only) is set, or the address is below 0x01000000, and the short space is not selected, the code is 0x39, 0x3A, 0x3D or 0x3E for function codes 1, 2, 5 or 6.
- R6: When configuration bit 2 (short-only) is set, or the address is at or above 0xFFFF0000, the short space is used even if the standard space is also selected. Function codes 1 and 2 give 0x29, and function codes 5 and 6 give 0x2D.
- R7: In all other cases the extended space is used. Function codes 1, 2, 5 and 6 give 0x09, 0x0A, 0x0D and 0x0E.
- R8: With override mode off, function codes 0, 3, 4 and 7 produce `cyc_invalid`=1, `am_valid`=0, `am_out`=0 and `d32_ok`=0.
- R9: When configuration bit 3 (override mode) is set, `am_out` equals `ovr_am` for any function code, and `am_valid` is 1.
- R10: The outputs change at the first rising edge after `cyc_req` is sampled high. In a cycle with no request, `am_valid`, `cyc_invalid`, `d32_ok` and `am_out` return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| loc_addr | input | 32 | Local register-access address |
| loc_wr | input | 1 | Register write strobe |
| loc_rd | input | 1 | Register read strobe |
| loc_wdata | input | 8 | Register write data |
| loc_rdata | output | 8 | Register read data |
| ovr_am | input | 6 | Programmed modifier used in override mode |
| cyc_req | input | 1 | Master cycle request |
| cyc_addr | input | 32 | Master cycle address |
| cyc_fc | input | 3 | Processor function code |
| am_out | output | 6 | Registered address-modifier code |
| d32_ok | output | 1 | 32-bit data transfer allowed |
| am_valid | output | 1 | Code is valid for a backplane cycle |
| cyc_invalid | output | 1 | Request rejected because the function code is unusable |

## Verification
A corrupted configuration bit shows up in two places. The next register read returns the wrong value, and the very next cycle request produces the wrong code family or the wrong data-width flag. Because the output stage is one register deep, a wrong space decision or a wrong function-code mapping appears on `am_out` exactly one clock after the request. A stuck output register shows up in the following idle cycle, because the idle outputs are required to be all zero. The address vectors sit on each window boundary, so an off-by-one limit changes the family or `d32_ok` on exactly one vector.

// File: rtl/am_select_pkg.sv
package am_select_pkg;

   localparam int CFG_W = 8;
   localparam int AM_W  = 6;
   localparam int FC_W  = 3;

   // configuration bit positions that the selector decodes
   localparam int CB_D16   = 0;
   localparam int CB_STD   = 1;
   localparam int CB_SHORT = 2;
   localparam int CB_OVR   = 3;

   typedef enum logic [1:0] {
      FAM_EXT   = 2'd0,
      FAM_STD   = 2'd1,
      FAM_SHORT = 2'd2
   } am_family_e;

   function automatic logic [AM_W-1:0] fam_base(am_family_e f);
      case (f)
         FAM_STD:   fam_base = 6'h38;
         FAM_SHORT: fam_base = 6'h28;
         default:   fam_base = 6'h08;
      endcase
   endfunction

endpackage

// File: rtl/am_select_cfg.sv
module am_select_cfg #(
   parameter int                ADDR_W   = 32,
   parameter int                W        = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 32'hFFFE_2005
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [W-1:0]      wdata,
   output logic [W-1:0]      rdata,
   output logic [W-1:0]      cfg_q
);

   logic hit;
   assign hit = (addr == CFG_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (wr && hit)
         cfg_q <= wdata;
   end

   assign rdata = (rd && hit) ? cfg_q : '0;

   AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit) |=> (cfg_q == $past(wdata))); // R2
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr || !hit) |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/am_select_space.sv
module am_select_space
   import am_select_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] D32_LIMIT  = 32'hF000_0000,
   parameter logic [ADDR_W-1:0] STD_LIMIT  = 32'h0100_0000,
   parameter logic [ADDR_W-1:0] SHORT_BASE = 32'hFFFF_0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              force_std,
   input  logic              force_short,
   input  logic              d16_only,
   output am_family_e        family,
   output logic              wide_ok
);

   initial begin
      AST_WINDOW_ORDER: assert (STD_LIMIT <= D32_LIMIT && D32_LIMIT <= SHORT_BASE)
         else $fatal(1, "address windows out of order"); // R4
   end

   logic in_std_win, in_short_win;
   assign in_std_win   = (addr < STD_LIMIT);
   assign in_short_win = (addr >= SHORT_BASE);

   // short selection is checked first and so wins over standard
   always_comb begin
      if (force_short || in_short_win)
         family = FAM_SHORT;
      else if (force_std || in_std_win)
         family = FAM_STD;
      else
         family = FAM_EXT;
   end

   assign wide_ok = !d16_only && (addr < D32_LIMIT);

endmodule

// File: rtl/am_select_code.sv
module am_select_code
   import am_select_pkg::*;
(
   input  am_family_e        family,
   input  logic [FC_W-1:0]   fc,
   output logic [AM_W-1:0]   code,
   output logic              bad_fc
);

   // usable function codes have exactly one of the two low bits set
   assign bad_fc = (fc[1] == fc[0]);

   always_comb begin
      if (family == FAM_SHORT)
         code = fam_base(family) | {3'b000, fc[2], 2'b01};
      else
         code = fam_base(family) | {3'b000, fc};
   end

endmodule

// File: rtl/am_select.sv
module am_select
   import am_select_pkg::*;
#(
   parameter int                ADDR_W       = 32,
   parameter logic [ADDR_W-1:0] CFG_ADDR     = 32'hFFFE_2005,
   parameter logic [ADDR_W-1:0] D32_LIMIT    = 32'hF000_0000,
   parameter logic [ADDR_W-1:0] STD_LIMIT    = 32'h0100_0000,
   parameter logic [ADDR_W-1:0] SHORT_BASE   = 32'hFFFF_0000,
   parameter bit                HAS_OVERRIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] loc_addr,
   input  logic              loc_wr,
   input  logic              loc_rd,
   input  logic [7:0]        loc_wdata,
   output logic [7:0]        loc_rdata,
   input  logic [5:0]        ovr_am,
   input  logic              cyc_req,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic [2:0]        cyc_fc,
   output logic [5:0]        am_out,
   output logic              d32_ok,
   output logic              am_valid,
   output logic              cyc_invalid
);

   initial begin
      AST_ADDR_WIDTH: assert (ADDR_W >= 17)
         else $fatal(1, "ADDR_W too small for the short window"); // R6
   end

   logic [CFG_W-1:0] cfg_q;
   am_family_e       family;
   logic             wide_ok, bad_fc, use_ovr;
   logic [AM_W-1:0]  derived;

   am_select_cfg #(.ADDR_W(ADDR_W), .W(CFG_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
      .clk(clk), .rst_n(rst_n), .addr(loc_addr), .wr(loc_wr), .rd(loc_rd),
      .wdata(loc_wdata), .rdata(loc_rdata), .cfg_q(cfg_q));

   am_select_space #(.ADDR_W(ADDR_W), .D32_LIMIT(D32_LIMIT),
      .STD_LIMIT(STD_LIMIT), .SHORT_BASE(SHORT_BASE)) u_space (
      .addr(cyc_addr), .force_std(cfg_q[CB_STD]), .force_short(cfg_q[CB_SHORT]),
      .d16_only(cfg_q[CB_D16]), .family(family), .wide_ok(wide_ok));

   am_select_code u_code (
      .family(family), .fc(cyc_fc), .code(derived), .bad_fc(bad_fc));

   generate
      if (HAS_OVERRIDE) begin : g_ovr
         assign use_ovr = cfg_q[CB_OVR];
      end else begin : g_no_ovr
         assign use_ovr = 1'b0;
      end
   endgenerate

   logic ok_n;
   assign ok_n = use_ovr || !bad_fc;

   always_ff @(posedge clk) begin
      if (!rst_n || !cyc_req) begin
         am_out      <= '0;
         d32_ok      <= 1'b0;
         am_valid    <= 1'b0;
         cyc_invalid <= 1'b0;
      end else begin
         am_valid    <= ok_n;
         cyc_invalid <= !ok_n;
         d32_ok      <= ok_n && wide_ok;
         if (use_ovr)
            am_out <= ovr_am;
         else if (bad_fc)
            am_out <= '0;
         else
            am_out <= derived;
      end
   end

   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_req |=> (!am_valid && !cyc_invalid && !d32_ok)); // R10
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(am_valid && cyc_invalid)); // R8
   AST_NO_D32_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_req && cyc_addr >= D32_LIMIT) |=> !d32_ok); // R4
   AST_SHORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_req && !use_ovr && cyc_fc[1] != cyc_fc[0]
       && (cfg_q[CB_SHORT] || cyc_addr >= SHORT_BASE)) |=> (am_out[5:3] == 3'b101)); // R6
   AST_BAD_FC_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_invalid |-> (am_out == '0 && !d32_ok)); // R8

   generate
      if (HAS_OVERRIDE) begin : g_ovr_chk
         AST_OVR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_req && cfg_q[CB_OVR]) |=> (am_valid && am_out == $past(ovr_am))); // R9
      end
   endgenerate

endmodule

// File: tb/sim_am_select.sv
module sim_am_select;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] loc_addr;
   logic        loc_wr, loc_rd;
   logic [7:0]  loc_wdata, loc_rdata;
   logic [5:0]  ovr_am;
   logic        cyc_req;
   logic [31:0] cyc_addr;
   logic [2:0]  cyc_fc;
   logic [5:0]  am_out;
   logic        d32_ok, am_valid, cyc_invalid;

   int checks = 0;
   int errors = 0;

   localparam logic [31:0] CFG_AT = 32'hFFFE_2005;

   always #10 clk = ~clk;

   am_select u0 (
      .clk(clk), .rst_n(rst_n), .loc_addr(loc_addr), .loc_wr(loc_wr),
      .loc_rd(loc_rd), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
      .ovr_am(ovr_am), .cyc_req(cyc_req), .cyc_addr(cyc_addr), .cyc_fc(cyc_fc),
      .am_out(am_out), .d32_ok(d32_ok), .am_valid(am_valid),
      .cyc_invalid(cyc_invalid));

   // {cfg, addr, fc, expected code, expected d32, expected invalid, tag}
   localparam int NV = 18;
   localparam logic [50:0] VEC [NV] = '{
      {8'h00, 32'h0000_1000, 3'd1, 6'h39, 1'b1, 1'b0},  // R5
      {8'h00, 32'h00FF_FFFF, 3'd6, 6'h3E, 1'b1, 1'b0},  // R5 boundary
      {8'h00, 32'h0100_0000, 3'd2, 6'h0A, 1'b1, 1'b0},  // R7 boundary
      {8'h00, 32'h8000_0000, 3'd5, 6'h0D, 1'b1, 1'b0},  // R7
      {8'h00, 32'hEFFF_FFFF, 3'd1, 6'h09, 1'b1, 1'b0},  // R4 boundary
      {8'h00, 32'hF000_0000, 3'd1, 6'h09, 1'b0, 1'b0},  // R4
      {8'h00, 32'hFFFE_FFFF, 3'd6, 6'h0E, 1'b0, 1'b0},  // R7 / R4
      {8'h00, 32'hFFFF_0000, 3'd1, 6'h29, 1'b0, 1'b0},  // R6 boundary
      {8'h00, 32'hFFFF_FFFF, 3'd6, 6'h2D, 1'b0, 1'b0},  // R6
      {8'h02, 32'h4000_0000, 3'd5, 6'h3D, 1'b1, 1'b0},  // R5 by bit
      {8'h02, 32'h4000_0000, 3'd2, 6'h3A, 1'b1, 1'b0},  // R5
      {8'h04, 32'h0000_0100, 3'd2, 6'h29, 1'b1, 1'b0},  // R6 beats std window
      {8'h06, 32'h2000_0000, 3'd5, 6'h2D, 1'b1, 1'b0},  // R6 beats std bit
      {8'h01, 32'h0000_0000, 3'd1, 6'h39, 1'b0, 1'b0},  // R4 d16
      {8'h00, 32'h1000_0000, 3'd0, 6'h00, 1'b0, 1'b1},  // R8
      {8'h00, 32'hFFFF_8000, 3'd7, 6'h00, 1'b0, 1'b1},  // R8
      {8'h02, 32'h0000_0000, 3'd3, 6'h00, 1'b0, 1'b1},  // R8
      {8'h04, 32'h0000_0000, 3'd4, 6'h00, 1'b0, 1'b1}   // R8
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [31:0] a, input logic [7:0] d);
      @(negedge clk);
      loc_addr = a; loc_wdata = d; loc_wr = 1'b1;
      @(negedge clk);
      loc_wr = 1'b0;
   endtask

   task automatic cfg_read(input logic [31:0] a, output logic [7:0] d);
      @(negedge clk);
      loc_addr = a; loc_rd = 1'b1;
      #2 d = loc_rdata;
      loc_rd = 1'b0;
   endtask

   task automatic run_cycle(input logic [31:0] a, input logic [2:0] f);
      @(negedge clk);
      cyc_addr = a; cyc_fc = f; cyc_req = 1'b1;
      @(negedge clk);
      cyc_req = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rv;
      rst_n = 1'b0; loc_addr = '0; loc_wr = 0; loc_rd = 0; loc_wdata = '0;
      ovr_am = '0; cyc_req = 0; cyc_addr = '0; cyc_fc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cfg_read(CFG_AT, rv);
      check("R1 cfg", rv, 8'h00);
      check("R1 outs", {am_out, d32_ok, am_valid, cyc_invalid}, 9'h000);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [50:0] v;
         v = VEC[i];
         cfg_write(CFG_AT, v[50:43]);
         run_cycle(v[42:11], v[10:8]);
         check("R5 R6 R7 code", am_out, v[7:2]);
         check("R4 d32", d32_ok, v[1]);
         check("R8 invalid", cyc_invalid, v[0]);
         check("R8 valid", am_valid, !v[0]);
      end

      // R2 write/readback, write elsewhere ignored
      cfg_write(CFG_AT, 8'hA5);
      cfg_read(CFG_AT, rv);
      check("R2 readback", rv, 8'hA5);
      cfg_write(32'hFFFE_2004, 8'hFF);
      cfg_read(CFG_AT, rv);
      check("R2 other addr ignored", rv, 8'hA5);

      // R3 read gating
      cfg_read(32'hFFFE_2006, rv);
      check("R3 wrong addr", rv, 8'h00);
      @(negedge clk); loc_addr = CFG_AT; loc_rd = 1'b0;
      #2 check("R3 no strobe", loc_rdata, 8'h00);

      // R9 override with unusable and usable function codes
      cfg_write(CFG_AT, 8'h08);
      ovr_am = 6'h3F;
      run_cycle(32'h0000_0010, 3'd0);
      check("R9 code", am_out, 6'h3F);
      check("R9 valid", {am_valid, cyc_invalid}, 2'b10);
      ovr_am = 6'h15;
      run_cycle(32'hFFFF_0000, 3'd5);
      check("R9 code short addr", am_out, 6'h15);

      // R10 latency and idle return
      cfg_write(CFG_AT, 8'h00);
      @(negedge clk);
      cyc_addr = 32'h0200_0000; cyc_fc = 3'd1; cyc_req = 1'b1;
      #2 check("R10 before edge", am_valid, 1'b0);
      @(negedge clk);
      cyc_req = 1'b0;
      check("R10 after edge", {am_valid, am_out}, {1'b1, 6'h09});
      @(negedge clk);
      check("R10 idle", {am_out, d32_ok, am_valid, cyc_invalid}, 9'h000);

      // R1 reset clears a loaded register
      cfg_write(CFG_AT, 8'hFF);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      cfg_read(CFG_AT, rv);
      check("R1 after reset", rv, 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule